// File: doc/BRIEF.md
# Serial Transmit Collision Detector

This block sits beside the transmit side of a UART-style serial port that drives a single-wire, half-duplex bus such as a LIN-style link. Because the node hears its own transmission on the shared wire, every bit it sends can be read back and compared with the bit it meant to send. One compare is made per bit period, on a selectable sub-bit tick. A disagreement means another node is driving the bus. The frame is then cut short, the line is returned to idle, any byte waiting to be sent is dropped, and a sticky error flag is raised. That flag blocks new frames until software clears it.

A simple transmitter stub is part of the block so that the abort, the buffer flush and the status flags can be seen at the ports. The stub has a one-byte holding buffer and a frame shifter. A frame is one start bit, the data bits sent LSB first, and one stop bit. Each bit lasts a fixed number of sub-bit ticks. The ticks are supplied by an external baud strobe. The receive input is expected to be synchronised to `clk` already.

Top module: `txcoll_guard`

## Requirements
- R1: After reset the line is at idle level (`txd` equals the inverse of `tx_inv`). `tx_empty` and `tx_done` are 1, and `tx_busy`, `bit_err` and `irq` are 0.
- R2: A frame is a logical 0 start bit, then DATA_W data bits LSB first, then a logical 1 stop bit. Each bit lasts TICKS `tick_en` pulses. `txd` is the logical level XOR `tx_inv`. When not sending, the logical level is 1.
- R3: A `wr_stb` pulse while idle makes `tx_empty` 0 on the next cycle. The frame starts one cycle later: `tx_busy` is 1, `tx_empty` is 1 and `tx_done` is 0. `tx_done` returns to 1 once the stop bit ends.
- R4: Mode 01 compares on tick 9 of each bit and mode 10 compares on tick 13. Ticks are numbered 0 to 15 from the start of the bit. The compare uses `rx_sync` XOR `rx_inv` against the intended logical bit. A disagreement on any other tick is ignored.
- R5: Modes 00 and 11 disable detection. While either is selected, `bit_err` is 0 on the following cycle.
- R6: While no frame is in progress, no mismatch is flagged, whatever the bus level.
- R7: On the clock edge that samples a mismatch, the frame is aborted. After that edge `tx_busy` is 0, `txd` is at idle level, `tx_empty` and `tx_done` are 1, and `bit_err` is 1.
- R8: A byte waiting in the buffer when a mismatch occurs is discarded. It is never sent, even after the flag is cleared.
- R9: While `bit_err` is 1, a write is held in the buffer but no frame starts. The frame starts on the second cycle after the flag is cleared.
- R10: A one-cycle `err_clr` pulse clears `bit_err`. If `err_clr` arrives in the same cycle as a new mismatch, the flag is set.
- R11: `irq` is 1 exactly when `bit_err` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Sub-bit tick strobe, TICKS per bit |
| mode | input | 2 | Detection mode: 01 early compare, 10 late compare, 00/11 off |
| tx_inv | input | 1 | Invert transmit line |
| rx_inv | input | 1 | Invert receive line |
| rx_sync | input | 1 | Synchronised bus level read back |
| wr_stb | input | 1 | Write strobe for the holding buffer |
| wr_data | input | DATA_W | Byte to transmit |
| err_clr | input | 1 | One-cycle clear of the error flag |
| txd | output | 1 | Transmit line |
| tx_busy | output | 1 | Frame in progress |
| tx_empty | output | 1 | Holding buffer empty |
| tx_done | output | 1 | No frame in progress and buffer empty |
| bit_err | output | 1 | Sticky collision flag |
| irq | output | 1 | Interrupt request for the collision flag |

## Verification
The bench builds the block with its default parameters: eight data bits, sixteen ticks per bit, and compare points on ticks 9 and 13. With these values a whole ten-bit frame takes a few hundred cycles. Both compare points, and the ticks next to them, can be hit by injecting a one-tick disturbance on the bus. Random gaps between tick pulses show that the compare depends on the tick count and not on cycle count.

// File: rtl/txcoll_guard.sv
module txcoll_guard #(
  parameter int DATA_W       = 8,
  parameter int TICKS        = 16,
  parameter int SAMPLE_EARLY = 9,
  parameter int SAMPLE_LATE  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [1:0]        mode,
  input  logic              tx_inv,
  input  logic              rx_inv,
  input  logic              rx_sync,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              err_clr,
  output logic              txd,
  output logic              tx_busy,
  output logic              tx_empty,
  output logic              tx_done,
  output logic              bit_err,
  output logic              irq
);
  localparam int FRAME = DATA_W + 2;
  localparam int TW = $clog2(TICKS);
  localparam int BW = $clog2(FRAME);
  localparam logic [1:0] MODE_EARLY = 2'b01;
  localparam logic [1:0] MODE_LATE  = 2'b10;

  logic [DATA_W-1:0] buf_q;
  logic              buf_full;
  logic              busy;
  logic [FRAME-1:0]  sh_q;
  logic [TW-1:0]     tick_q;
  logic [BW-1:0]     bit_q;
  logic              err_q;

  wire          det_on   = (mode == MODE_EARLY) || (mode == MODE_LATE);
  wire [TW-1:0] samp     = (mode == MODE_LATE) ? TW'(SAMPLE_LATE) : TW'(SAMPLE_EARLY);
  wire          tx_lvl   = busy ? sh_q[0] : 1'b1;
  wire          rx_lvl   = rx_sync ^ rx_inv;
  wire          mismatch = busy && tick_en && det_on && (tick_q == samp) && (rx_lvl != tx_lvl);
  wire          bit_end  = busy && tick_en && (tick_q == TW'(TICKS - 1));
  wire          last_bit = (bit_q == BW'(FRAME - 1));
  wire          start    = !busy && buf_full && !err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (!det_on) begin
      err_q <= 1'b0;
    end else if (mismatch) begin
      err_q <= 1'b1;
    end else if (err_clr) begin
      err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q    <= '0;
      buf_full <= 1'b0;
    end else if (mismatch) begin
      buf_full <= 1'b0;
    end else if (wr_stb) begin
      buf_q    <= wr_data;
      buf_full <= 1'b1;
    end else if (start) begin
      buf_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sh_q   <= '1;
      tick_q <= '0;
      bit_q  <= '0;
    end else if (mismatch) begin
      busy   <= 1'b0;
      sh_q   <= '1;
    end else if (start) begin
      busy   <= 1'b1;
      sh_q   <= {1'b1, buf_q, 1'b0};
      tick_q <= '0;
      bit_q  <= '0;
    end else if (bit_end) begin
      tick_q <= '0;
      sh_q   <= {1'b1, sh_q[FRAME-1:1]};
      bit_q  <= bit_q + BW'(1);
      if (last_bit) busy <= 1'b0;
    end else if (busy && tick_en) begin
      tick_q <= tick_q + TW'(1);
    end
  end

  assign txd      = tx_lvl ^ tx_inv;
  assign tx_busy  = busy;
  assign tx_empty = !buf_full;
  assign tx_done  = !busy && !buf_full;
  assign bit_err  = err_q;
  assign irq      = err_q;
endmodule

module txcoll_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       tx_inv,
  input logic       wr_stb,
  input logic       err_clr,
  input logic       txd,
  input logic       tx_busy,
  input logic       tx_empty,
  input logic       tx_done,
  input logic       bit_err,
  input logic       irq
);
  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> (txd == !tx_inv));
  // R3
  write_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !tx_busy) |=> !tx_empty);
  // R5
  off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 || mode == 2'b11) |=> !bit_err);
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !bit_err && !$isunknown(mode)) |=> !bit_err);
  // R7
  abort_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_err) |-> (!tx_busy && tx_empty && tx_done));
  // R9
  blocked_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_err && !tx_busy) |=> !tx_busy);
  // R10
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_err && err_clr) |=> !bit_err);
  // R11
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == bit_err);
endmodule

bind txcoll_guard txcoll_guard_chk u_chk (.*);

// File: tb/txcoll_guard_bench.sv
module txcoll_guard_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [1:0] mode = 2'b01;
  logic       tx_inv = 1'b0;
  logic       rx_inv = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic       err_clr = 1'b0;
  logic       inj_en = 1'b0;
  logic       inj_val = 1'b0;
  logic       txd, tx_busy, tx_empty, tx_done, bit_err, irq;
  logic       rx_sync;
  int checks = 0;
  int errs = 0;

  assign rx_sync = inj_en ? inj_val : txd;

  always #10 clk = ~clk;

  txcoll_guard u_txcoll_guard (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode(mode),
    .tx_inv(tx_inv), .rx_inv(rx_inv), .rx_sync(rx_sync),
    .wr_stb(wr_stb), .wr_data(wr_data), .err_clr(err_clr),
    .txd(txd), .tx_busy(tx_busy), .tx_empty(tx_empty),
    .tx_done(tx_done), .bit_err(bit_err), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_samp(input logic [1:0] m);
    if (m == 2'b01) return 9;
    if (m == 2'b10) return 13;
    return -1;
  endfunction

  function automatic logic fbit(input logic [7:0] d, input int b);
    if (b == 0) return 1'b0;
    if (b == 9) return 1'b1;
    return d[b-1];
  endfunction

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic tick_once();
    tick_en = 1'b1; cyc(); tick_en = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] d);
    wr_stb = 1'b1; wr_data = d; cyc(); wr_stb = 1'b0;
  endtask

  task automatic clear_err();
    err_clr = 1'b1; cyc(); err_clr = 1'b0;
    chk(!bit_err && !irq, "R10 clear", {bit_err, irq}, 0);
  endtask

  task automatic run_frame(input logic [7:0] d, input int ib, input int it, input bit clr_same);
    bit aborted = 0;
    bit hit = (exp_samp(mode) == it);
    chk(tx_busy && tx_empty && !tx_done, "R3 start", {tx_busy, tx_empty, tx_done}, 3'b110);
    for (int b = 0; b < 10; b++) begin
      for (int t = 0; t < 16; t++) begin
        if (!aborted) begin
          if (t == 0)
            chk(txd == (fbit(d, b) ^ tx_inv), "R2 bit", txd, fbit(d, b) ^ tx_inv);
          repeat ($urandom_range(2, 0)) cyc();
          inj_en  = (b == ib) && (t == it);
          inj_val = !txd;
          err_clr = clr_same && inj_en;
          tick_en = 1'b1;
          cyc();
          tick_en = 1'b0; inj_en = 1'b0; err_clr = 1'b0;
          if (b == ib && t == it && hit) begin
            aborted = 1;
            chk(bit_err, "R7 flag", bit_err, 1);
            chk(!tx_busy && tx_empty && tx_done, "R7 abort", {tx_busy, tx_empty, tx_done}, 3'b011);
            chk(txd == !tx_inv, "R7 idle level", txd, !tx_inv);
            chk(irq, "R11 irq", irq, 1);
            if (clr_same) chk(bit_err, "R10 set wins", bit_err, 1);
          end
        end
      end
    end
    if (!aborted) begin
      chk(!bit_err, "R4 no error", bit_err, 0);
      chk(!tx_busy && tx_done && txd == !tx_inv, "R3 done", {tx_busy, tx_done}, 2'b01);
    end
  endtask

  task automatic send(input logic [7:0] d, input int ib, input int it, input bit clr_same);
    write_byte(d);
    chk(!tx_empty, "R3 fill", tx_empty, 0);
    cyc();
    run_frame(d, ib, it, clr_same);
  endtask

  initial begin
    #(20 * 150000);
    errs++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk(txd == 1'b1 && tx_empty && tx_done && !tx_busy && !bit_err && !irq, "R1 reset",
        {txd, tx_empty, tx_done, tx_busy, bit_err, irq}, 6'b111000);
    rst_n = 1'b1;
    cyc();

    // R2 frames with detection off and with inverted lines
    mode = 2'b00; send(8'hA5, -1, 0, 0);
    mode = 2'b01; tx_inv = 1; rx_inv = 1; send(8'h3C, -1, 0, 0);
    tx_inv = 0; rx_inv = 0;

    // R4 early compare point
    send(8'h5A, 3, 8, 0);
    send(8'h5A, 3, 10, 0);
    send(8'h96, 4, 9, 0);
    clear_err();
    // R4 late compare point
    mode = 2'b10;
    send(8'h0F, 2, 9, 0);
    send(8'hF0, 6, 13, 0);
    clear_err();

    // R5 disabled modes ignore mismatches
    mode = 2'b00; send(8'h81, 5, 9, 0); send(8'h81, 5, 13, 0);
    mode = 2'b11; send(8'h7E, 1, 9, 0); send(8'h7E, 1, 13, 0);
    // R5 disabling clears the flag
    mode = 2'b01; send(8'h24, 2, 9, 0);
    mode = 2'b00; cyc();
    chk(!bit_err && !irq, "R5 off clears", bit_err, 0);
    mode = 2'b01;

    // R6 idle bus noise
    for (int i = 0; i < 40; i++) begin
      inj_en = 1'b1; inj_val = !txd; tick_once(); inj_en = 1'b0;
    end
    chk(!bit_err && !tx_busy, "R6 idle", bit_err, 0);

    // R8 buffered byte discarded
    write_byte(8'h11); cyc();
    write_byte(8'h22);
    chk(!tx_empty, "R8 buffered", tx_empty, 0);
    for (int t = 0; t < 9; t++) tick_once();
    inj_en = 1'b1; inj_val = !txd; tick_once(); inj_en = 1'b0;
    chk(bit_err && tx_empty, "R8 flushed", {bit_err, tx_empty}, 2'b11);
    clear_err();
    for (int i = 0; i < 40; i++) begin
      tick_once();
      chk(!tx_busy && txd == 1'b1, "R8 nothing sent", {tx_busy, txd}, 2'b01);
    end

    // R9 blocked until cleared
    send(8'h5C, 0, 9, 0);
    write_byte(8'hC3);
    for (int i = 0; i < 30; i++) begin
      tick_once();
      chk(!tx_busy && !tx_empty && txd == 1'b1, "R9 blocked", {tx_busy, tx_empty, txd}, 3'b001);
    end
    clear_err();
    chk(!tx_busy, "R9 not yet", tx_busy, 0);
    cyc();
    run_frame(8'hC3, -1, 0, 0);

    // R10 clear collides with mismatch
    send(8'h77, 7, 9, 1);
    clear_err();

    // R4 polarities corrected separately
    tx_inv = 1; rx_inv = 0;
    write_byte(8'h00); cyc();
    for (int t = 0; t < 9; t++) tick_once();
    chk(!bit_err, "R4 before sample", bit_err, 0);
    tick_once();
    chk(bit_err, "R4 polarity mismatch", bit_err, 1);
    clear_err();
    tx_inv = 0;

    // random frames
    for (int n = 0; n < 30; n++) begin
      logic [7:0] d = 8'($urandom);
      int ib, it;
      mode = 2'($urandom);
      tx_inv = 1'($urandom); rx_inv = tx_inv;
      ib = ($urandom_range(3, 0) == 0) ? -1 : int'($urandom_range(9, 0));
      it = ($urandom_range(1, 0) == 0 && exp_samp(mode) >= 0) ? exp_samp(mode) : int'($urandom_range(15, 0));
      send(d, ib, it, 0);
      if (bit_err) clear_err();
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule